// File: doc/BRIEF.md
# Multi-Mode LUT Logic Element

This block is one programmable logic cell: a 4-input lookup table feeding a single storage bit whose next-state rule is chosen by a mode field. The table contents arrive on a 16-bit configuration port. The bit indexed by the four data inputs, with `in_d` as the most significant index bit, drives the combinational result. An arithmetic option replaces the table with a one-bit adder or subtractor whose carry goes to the next cell in a chain.

The storage bit acts as a D, T, JK or SR flip-flop. Its state set is {0, 1} and its transitions are named HOLD, SET, RESET and TOGGLE; the mode picks which of these a clock edge takes. Three controls override the clocked path. An asynchronous clear forces the bit to 0. An asynchronous load copies a separate data bit into it. A clock enable blocks clocked updates and nothing else. A bypass select chooses whether the main output shows the table result or the stored bit.

Top module: `lut_logic_element`

## Requirements
- R1: With `arith_en`=0, `lut_out` equals `lut_mask[{in_d,in_c,in_b,in_a}]`.
- R2: With `arith_en`=1 and `sub_en`=0, `{cout, lut_out}` equals `in_a + in_b + cin`.
- R3: With `arith_en`=1 and `sub_en`=1, `{cout, lut_out}` equals `in_a + !in_b + cin`, so `cin`=1 means no borrow and `cout`=1 means no borrow out.
- R4: In D mode (`ff_mode`=0), a rising clock edge with `ena`=1 loads `lut_out` into `q`.
- R5: In T mode (`ff_mode`=1), a rising clock edge with `ena`=1 takes TOGGLE when `lut_out`=1 and HOLD when it is 0.
- R6: In JK mode (`ff_mode`=2), J is `in_c` and K is `in_d`. Per clock edge with `ena`=1: J=0,K=0 is HOLD; J=0,K=1 is RESET; J=1,K=0 is SET; J=1,K=1 is TOGGLE.
- R7: In SR mode (`ff_mode`=3), S is `in_c` and R is `in_d`. S=1,R=0 is SET; S=0,R=1 is RESET; both 0 or both 1 is HOLD.
- R8: With `ena`=0, clock edges leave `q` unchanged in every mode.
- R9: `clr`=1 forces `q` to 0 at once, without a clock, even while `aload`=1.
- R10: When `clr`=0, a rise of `aload` copies `adata` into `q` at once. While `aload` stays high, every clock edge reloads `adata`, whatever `ena` and the mode are.
- R11: `le_out` equals `lut_out` when `bypass`=1 and `q` when `bypass`=0.
- R12: `cout` is 0 whenever `arith_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| clr | input | 1 | Asynchronous clear, active high; also the block reset |
| aload | input | 1 | Asynchronous load of `adata`, active high |
| adata | input | 1 | Value loaded by `aload` |
| ena | input | 1 | Clock enable for clocked updates |
| ff_mode | input | 2 | Register behaviour: 0 D, 1 T, 2 JK, 3 SR |
| lut_mask | input | 16 | Lookup table contents |
| arith_en | input | 1 | Select arithmetic mode |
| sub_en | input | 1 | Subtract instead of add in arithmetic mode |
| bypass | input | 1 | Main output shows the table result instead of `q` |
| in_a | input | 1 | Table index bit 0 / first operand |
| in_b | input | 1 | Table index bit 1 / second operand |
| in_c | input | 1 | Table index bit 2 / J or S |
| in_d | input | 1 | Table index bit 3 / K or R |
| cin | input | 1 | Carry in from the previous cell |
| lut_out | output | 1 | Table result or sum bit |
| cout | output | 1 | Carry to the next cell |
| q | output | 1 | Stored bit |
| le_out | output | 1 | Selected main output |

## Verification
`lut_out`, `cout` and a bypassed `le_out` settle in the same cycle the inputs change. `q` and a registered `le_out` change on the first rising edge after the inputs are applied. Clear and load take effect without any edge. The driver changes inputs just after a falling edge and queues each expected value for the next falling edge. A single check point therefore sees the table result under the same inputs and the register after exactly one rising edge. Expected register values come from a model that is kept in the bench and follows R4 to R10.

// File: rtl/le_pkg.sv
package le_pkg;
    localparam int LUT_INPUTS = 4;

    typedef enum logic [1:0] {
        MODE_D  = 2'd0,
        MODE_T  = 2'd1,
        MODE_JK = 2'd2,
        MODE_SR = 2'd3
    } ff_mode_e;

    typedef enum logic [1:0] {
        TR_HOLD   = 2'd0,
        TR_SET    = 2'd1,
        TR_RESET  = 2'd2,
        TR_TOGGLE = 2'd3
    } ff_trans_e;
endpackage

// File: rtl/le_lut.sv
module le_lut #(
    parameter int N = 4,
    localparam int SIZE = 1 << N
) (
    input  logic            clk,
    input  logic            clr,
    input  logic [SIZE-1:0] mask_i,
    input  logic [N-1:0]    sel_i,
    input  logic            arith_i,
    input  logic            sub_i,
    input  logic            cin_i,
    output logic            lut_o,
    output logic            cout_o
);
    localparam int NODES = 2 * SIZE - 1;

    logic [NODES-1:0] node;
    logic             op_b;
    logic             sum;
    logic             carry;

    // Leaves hold the table contents in index order
    genvar gi;
    generate
        for (gi = 0; gi < SIZE; gi++) begin : g_leaf
            assign node[SIZE - 1 + gi] = mask_i[gi];
        end
    endgenerate

    // Binary mux tree, root selects on the most significant index bit
    genvar gl, gk;
    generate
        for (gl = 0; gl < N; gl++) begin : g_level
            for (gk = 0; gk < (1 << gl); gk++) begin : g_mux
                localparam int J = (1 << gl) - 1 + gk;
                assign node[J] = sel_i[N-1-gl] ? node[2*J+2] : node[2*J+1];
            end
        end
    endgenerate

    // Arithmetic path: second operand inverted for subtract
    always_comb begin
        op_b  = sel_i[1] ^ sub_i;
        sum   = sel_i[0] ^ op_b ^ cin_i;
        carry = (sel_i[0] & op_b) | (sel_i[0] & cin_i) | (op_b & cin_i);
    end

    always_comb begin
        if (arith_i) begin
            lut_o  = sum;
            cout_o = carry;
        end else begin
            lut_o  = node[0];
            cout_o = 1'b0;
        end
    end

    p_add_r2: assert property (@(posedge clk) disable iff (clr)
        (arith_i && !sub_i) |->
        ({cout_o, lut_o} == (2'(sel_i[0]) + 2'(sel_i[1]) + 2'(cin_i))));

    p_sub_r3: assert property (@(posedge clk) disable iff (clr)
        (arith_i && sub_i) |->
        ({cout_o, lut_o} == (2'(sel_i[0]) + 2'(!sel_i[1]) + 2'(cin_i))));

    p_cout_idle_r12: assert property (@(posedge clk) disable iff (clr)
        !arith_i |-> !cout_o);
endmodule

// File: rtl/le_next.sv
module le_next
    import le_pkg::*;
(
    input  ff_mode_e mode_i,
    input  logic     q_i,
    input  logic     lut_i,
    input  logic     j_i,
    input  logic     k_i,
    output logic     nxt_o
);
    ff_trans_e trans;

    // Pick the named transition for the active mode
    always_comb begin
        unique case (mode_i)
            MODE_D:  trans = lut_i ? TR_SET : TR_RESET;
            MODE_T:  trans = lut_i ? TR_TOGGLE : TR_HOLD;
            MODE_JK: begin
                unique case ({j_i, k_i})
                    2'b00:   trans = TR_HOLD;
                    2'b01:   trans = TR_RESET;
                    2'b10:   trans = TR_SET;
                    default: trans = TR_TOGGLE;
                endcase
            end
            MODE_SR: begin
                unique case ({j_i, k_i})
                    2'b10:   trans = TR_SET;
                    2'b01:   trans = TR_RESET;
                    default: trans = TR_HOLD;
                endcase
            end
            default: trans = TR_HOLD;
        endcase
    end

    // Apply it to the present state
    always_comb begin
        unique case (trans)
            TR_SET:    nxt_o = 1'b1;
            TR_RESET:  nxt_o = 1'b0;
            TR_TOGGLE: nxt_o = ~q_i;
            default:   nxt_o = q_i;
        endcase
    end
endmodule

// File: rtl/le_reg.sv
module le_reg (
    input  logic clk,
    input  logic clr,
    input  logic aload_i,
    input  logic adata_i,
    input  logic ena_i,
    input  logic nxt_i,
    output logic q_o
);
    // Clear over load over clocked update; enable gates only the clocked path
    always_ff @(posedge clk or posedge clr or posedge aload_i) begin
        if (clr)
            q_o <= 1'b0;
        else if (aload_i)
            q_o <= adata_i;
        else if (ena_i)
            q_o <= nxt_i;
    end

    p_clr_zero_r9: assert property (@(posedge clk) clr |-> !q_o);

    p_aload_r10: assert property (@(posedge clk) disable iff (clr)
        aload_i |-> (q_o == adata_i));
endmodule

// File: rtl/lut_logic_element.sv
module lut_logic_element
    import le_pkg::*;
#(
    parameter int N = LUT_INPUTS,
    localparam int SIZE = 1 << N
) (
    input  logic            clk,
    input  logic            clr,
    input  logic            aload,
    input  logic            adata,
    input  logic            ena,
    input  logic [1:0]      ff_mode,
    input  logic [SIZE-1:0] lut_mask,
    input  logic            arith_en,
    input  logic            sub_en,
    input  logic            bypass,
    input  logic            in_a,
    input  logic            in_b,
    input  logic            in_c,
    input  logic            in_d,
    input  logic            cin,
    output logic            lut_out,
    output logic            cout,
    output logic            q,
    output logic            le_out
);
    ff_mode_e     mode;
    logic [N-1:0] sel;
    logic         nxt;

    assign mode = ff_mode_e'(ff_mode);

    always_comb begin
        sel    = '0;
        sel[0] = in_a;
        sel[1] = in_b;
        sel[2] = in_c;
        sel[3] = in_d;
    end

    le_lut #(.N(N)) u_lut (
        .clk     (clk),
        .clr     (clr),
        .mask_i  (lut_mask),
        .sel_i   (sel),
        .arith_i (arith_en),
        .sub_i   (sub_en),
        .cin_i   (cin),
        .lut_o   (lut_out),
        .cout_o  (cout)
    );

    le_next u_next (
        .mode_i (mode),
        .q_i    (q),
        .lut_i  (lut_out),
        .j_i    (in_c),
        .k_i    (in_d),
        .nxt_o  (nxt)
    );

    le_reg u_reg (
        .clk     (clk),
        .clr     (clr),
        .aload_i (aload),
        .adata_i (adata),
        .ena_i   (ena),
        .nxt_i   (nxt),
        .q_o     (q)
    );

    always_comb le_out = bypass ? lut_out : q;

    p_dmode_r4: assert property (@(posedge clk) disable iff (clr || aload)
        (mode == MODE_D && ena) |=> (q == $past(lut_out)));

    p_tmode_r5: assert property (@(posedge clk) disable iff (clr || aload)
        (mode == MODE_T && ena && lut_out) |=> (q != $past(q)));

    p_jk_set_r6: assert property (@(posedge clk) disable iff (clr || aload)
        (mode == MODE_JK && ena && in_c && !in_d) |=> q);

    p_sr_hold_r7: assert property (@(posedge clk) disable iff (clr || aload)
        (mode == MODE_SR && ena && in_c && in_d) |=> $stable(q));

    p_ena_hold_r8: assert property (@(posedge clk) disable iff (clr || aload)
        !ena |=> $stable(q));
endmodule

// File: tb/lut_logic_element_test.sv
`timescale 1ns/1ps
module lut_logic_element_test;
    typedef struct {
        logic        clr, aload, adata, ena;
        logic [1:0]  mode;
        logic [15:0] mask;
        logic        arith, sub, bypass;
        logic        a, b, c, d, cin;
    } stim_t;

    typedef struct {
        string tag;
        int    sel;
        logic  exp;
        int    due;
    } item_t;

    logic clk = 1'b0;
    logic clr = 1'b1, aload = 1'b0, adata = 1'b0, ena = 1'b0;
    logic [1:0] ff_mode = 2'd0;
    logic [15:0] lut_mask = 16'h0;
    logic arith_en = 1'b0, sub_en = 1'b0, bypass = 1'b0;
    logic in_a = 1'b0, in_b = 1'b0, in_c = 1'b0, in_d = 1'b0, cin = 1'b0;
    logic lut_out, cout, q, le_out;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic mq = 1'b0;
    item_t sb[$];

    always #5 clk = ~clk;

    lut_logic_element uut (
        .clk(clk), .clr(clr), .aload(aload), .adata(adata), .ena(ena),
        .ff_mode(ff_mode), .lut_mask(lut_mask), .arith_en(arith_en),
        .sub_en(sub_en), .bypass(bypass), .in_a(in_a), .in_b(in_b),
        .in_c(in_c), .in_d(in_d), .cin(cin), .lut_out(lut_out),
        .cout(cout), .q(q), .le_out(le_out)
    );

    function automatic stim_t base();
        stim_t s;
        s.clr = 0; s.aload = 0; s.adata = 0; s.ena = 1; s.mode = 2'd0;
        s.mask = 16'h0; s.arith = 0; s.sub = 0; s.bypass = 0;
        s.a = 0; s.b = 0; s.c = 0; s.d = 0; s.cin = 0;
        return s;
    endfunction

    function automatic logic exp_lut(stim_t s);
        logic bb;
        if (!s.arith) return s.mask[{s.d, s.c, s.b, s.a}];
        bb = s.b ^ s.sub;
        return s.a ^ bb ^ s.cin;
    endfunction

    function automatic logic exp_cout(stim_t s);
        logic bb;
        if (!s.arith) return 1'b0;
        bb = s.b ^ s.sub;
        return (s.a & bb) | (s.a & s.cin) | (bb & s.cin);
    endfunction

    task automatic push(string tag, int sel, logic e);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = e; it.due = cyc + 1;
        sb.push_back(it);
    endtask

    // Driver: apply stimulus after a falling edge, queue results due at the next one
    task automatic step(stim_t s, string tag);
        logic l;
        @(negedge clk);
        #1;
        clr = s.clr; aload = s.aload; adata = s.adata; ena = s.ena;
        ff_mode = s.mode; lut_mask = s.mask; arith_en = s.arith;
        sub_en = s.sub; bypass = s.bypass; in_a = s.a; in_b = s.b;
        in_c = s.c; in_d = s.d; cin = s.cin;
        l = exp_lut(s);
        if (s.clr) mq = 1'b0;
        else if (s.aload) mq = s.adata;
        else if (s.ena) begin
            case (s.mode)
                2'd0: mq = l;
                2'd1: mq = mq ^ l;
                2'd2: mq = (s.c && !s.d) ? 1'b1 : (!s.c && s.d) ? 1'b0 :
                           (s.c && s.d) ? ~mq : mq;
                default: mq = (s.c && !s.d) ? 1'b1 : (!s.c && s.d) ? 1'b0 : mq;
            endcase
        end
        push(tag, 0, l);
        push(tag, 1, exp_cout(s));
        push(tag, 2, mq);
        push(tag, 3, s.bypass ? l : mq);
    endtask

    // Monitor: compare queued expectations at their due falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            logic act;
            it = sb.pop_front();
            case (it.sel)
                0: act = lut_out;
                1: act = cout;
                2: act = q;
                default: act = le_out;
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s output%0d actual=%b expected=%b", it.tag, it.sel, act, it.exp);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        stim_t s;
        // R9: reset state, and clear over load
        s = base(); s.clr = 1; step(s, "R9");
        s.aload = 1; s.adata = 1; step(s, "R9");
        s = base(); s.ena = 0; step(s, "R9");
        // R1: every table index, two masks
        for (int i = 0; i < 16; i++) begin
            s = base(); s.mask = 16'hB3C5;
            {s.d, s.c, s.b, s.a} = 4'(i);
            step(s, "R1");
        end
        for (int i = 0; i < 16; i++) begin
            s = base(); s.mask = 16'h6996; s.bypass = 1;
            {s.d, s.c, s.b, s.a} = 4'(15 - i);
            step(s, "R1");
        end
        // R2 and R3: all operand and carry combinations
        for (int i = 0; i < 16; i++) begin
            s = base(); s.arith = 1; s.sub = i[3];
            {s.d, s.cin, s.b, s.a} = {1'b0, 3'(i)};
            s.c = i[0];
            step(s, s.sub ? "R3" : "R2");
        end
        // R4: D mode follows the table
        for (int i = 0; i < 6; i++) begin
            s = base(); s.mask = 16'h00FF; s.d = i[0]; s.a = i[1];
            step(s, "R4");
        end
        // R5: T mode, table output equals in_a
        for (int i = 0; i < 8; i++) begin
            s = base(); s.mode = 2'd1; s.mask = 16'hAAAA; s.a = (i % 3) != 0;
            step(s, "R5");
        end
        // R6: JK all four codes, twice
        for (int i = 0; i < 8; i++) begin
            s = base(); s.mode = 2'd2; s.c = i[1]; s.d = i[0];
            step(s, "R6");
        end
        s = base(); s.mode = 2'd2; s.c = 1; s.d = 1; step(s, "R6"); step(s, "R6");
        // R7: SR codes including both set
        for (int i = 0; i < 8; i++) begin
            s = base(); s.mode = 2'd3; s.c = i[2] ^ i[0]; s.d = i[1];
            step(s, "R7");
        end
        // R8: enable low in each mode, table and JK inputs pushing a change
        s = base(); s.mask = 16'hFFFF; step(s, "R8");
        for (int m = 0; m < 4; m++) begin
            s = base(); s.ena = 0; s.mode = 2'(m); s.mask = 16'h0000;
            s.c = 0; s.d = 1; step(s, "R8");
        end
        s = base(); s.ena = 0; s.mode = 2'd1; s.mask = 16'hFFFF; step(s, "R8");
        // R10: asynchronous load overrides clocked update and enable
        s = base(); s.mask = 16'h0000; step(s, "R10");
        s.aload = 1; s.adata = 1; step(s, "R10"); step(s, "R10");
        s.aload = 0; s.ena = 0; step(s, "R10");
        s.aload = 1; s.adata = 0; s.mode = 2'd3; s.c = 1; step(s, "R10");
        s.aload = 0; step(s, "R10");
        // R11: bypass select both ways
        s = base(); s.mask = 16'hFFFF; s.bypass = 0; step(s, "R11");
        s.mask = 16'h0000; s.ena = 0; s.bypass = 1; step(s, "R11");
        s.bypass = 0; step(s, "R11");
        // R12: carry idle outside arithmetic with carry-generating inputs
        s = base(); s.a = 1; s.b = 1; s.cin = 1; s.mask = 16'h8000; step(s, "R12");
        s.sub = 1; s.d = 1; s.c = 1; step(s, "R12");
        // R9: clear mid-run
        s = base(); s.mask = 16'hFFFF; step(s, "R9");
        s.clr = 1; step(s, "R9");
        s.clr = 0; s.mask = 16'h0; s.ena = 0; step(s, "R9");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule